// File: doc/BRIEF.md
# Stream Receive Packet Mailbox

This block takes 32-bit words from an AXI4-Stream slave port and stores them in a data FIFO. Each time a word with TLAST is accepted, the word count of that packet goes into a separate length queue. A processor empties the mailbox through a simple register read/write port. It first reads the occupancy register and waits for a nonzero value. It then reads the length register, which gives the oldest complete packet's size in bytes and removes that entry. Finally it reads the data register once for each word of the packet.

Reading the length register sets up a word budget for the packet. A read-protocol state machine enforces that budget and reports three kinds of misuse as separate error bits: leaving a packet before all its words are read, reading past the end of a packet, and reading while the FIFO is empty. A received packet and a finished flush also raise status bits. The status register is cleared by writing 1s, and an enable register gates which status bits drive the interrupt line. The receive flush register and the stream reset register act only when written with the key value 0xA5.

The read-protocol state machine has three states:
- RD_IDLE: no budget is armed.
- RD_DRAIN: the budget is nonzero.
- RD_FLUSH: one cycle in which both stores are emptied.

It has these transitions:
- arm: RD_IDLE to RD_DRAIN, on a length read while a packet is queued.
- rearm: RD_DRAIN to RD_DRAIN, on a length read that finds another packet.
- disarm: RD_DRAIN to RD_IDLE, on a length read that finds no packet.
- last_word: RD_DRAIN to RD_IDLE, when the data read that uses up the budget pops its word.
- key: from any state to RD_FLUSH, on a key write to either reset register.
- flush_done: RD_FLUSH to RD_IDLE, always one cycle after entry.

Top module: `stream_rx_mailbox`

## Requirements
- R1: After reset the status and enable registers read 0, occupancy reads 0, `s_tready` is 1 and `irq` is 0.
- R2: A word is stored when `s_tvalid` and `s_tready` are both 1. `s_tready` is 0 while the data FIFO holds DATA_DEPTH words or while the length queue holds LEN_DEPTH entries.
- R3: The occupancy register (offset 0x08) returns the number of words in the data FIFO.
- R4: A length read (offset 0x0C) returns 4 times the word count of the oldest complete packet and removes that entry. When no packet is complete, it returns 0 and leaves the budget at 0.
- R5: Each data read (offset 0x10) that is within the budget returns the next word in arrival order and removes it.
- R6: Accepting a word with TLAST sets status bit 26.
- R7: A data read with no budget left while the FIFO holds words sets status bit 30. It returns 0 and removes nothing.
- R8: A length read while budget remains sets status bit 31. The new packet's budget replaces the old one.
- R9: A data read while the FIFO is empty sets status bit 29 and returns 0.
- R10: Writing 0xA5 to offset 0x14 empties the data FIFO, the length queue and any partly received packet, and sets status bit 23 one cycle after the write. Writing any other value there has no effect.
- R11: Writing 0xA5 to offset 0x18 does everything R10 does. It also clears the status and enable registers at the write, so afterwards the status reads exactly 0x00800000.
- R12: Status (offset 0x00) bits clear where a 1 is written. Enable (offset 0x04) keeps only the mask 0xE4800000. `irq` is the OR of status AND enable.
- R13: `s_tready` is 0 in the cycle after a key write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | 32 | Stream data word |
| s_tvalid | input | 1 | Stream word valid |
| s_tlast | input | 1 | Last word of packet |
| s_tready | output | 1 | Stream ready |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_rdata | output | 32 | Register read data for the current address |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets these corner cases, each with the failure a faulty design would show:
- Reading past the end of a packet while the next packet's word is already buffered. A design that popped on that read would lose the word, and both the occupancy check and the next packet's data check would fail.
- Re-reading the length in the middle of a packet. This must raise the under-read bit and still serve the next length.
- Filling the length queue with one-word packets, and separately filling the data FIFO with a single long packet. A design that ignored either full condition would drop a length or a word.
- Flushing after a partial packet. A design that kept the ingress word counter would report a wrong length for the next packet.
- Writing a wrong key to the flush register. A design that did not compare the key would wrongly empty the FIFO.

// File: rtl/srm_pkg.sv
`timescale 1ns/1ps
package srm_pkg;
    localparam int REG_AW = 6;

    localparam logic [REG_AW-1:0] OFS_STATUS  = 6'h00;
    localparam logic [REG_AW-1:0] OFS_ENABLE  = 6'h04;
    localparam logic [REG_AW-1:0] OFS_OCC     = 6'h08;
    localparam logic [REG_AW-1:0] OFS_LEN     = 6'h0C;
    localparam logic [REG_AW-1:0] OFS_DATA    = 6'h10;
    localparam logic [REG_AW-1:0] OFS_RXRST   = 6'h14;
    localparam logic [REG_AW-1:0] OFS_STRMRST = 6'h18;

    localparam logic [31:0] RESET_KEY = 32'h0000_00A5;

    localparam int BIT_UNDER_RD = 31;
    localparam int BIT_OVER_RD  = 30;
    localparam int BIT_UNDERRUN = 29;
    localparam int BIT_RX_DONE  = 26;
    localparam int BIT_RST_DONE = 23;

    localparam logic [31:0] IRQ_MASK = (32'd1 << BIT_UNDER_RD) | (32'd1 << BIT_OVER_RD)
                                     | (32'd1 << BIT_UNDERRUN) | (32'd1 << BIT_RX_DONE)
                                     | (32'd1 << BIT_RST_DONE);

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_DRAIN = 2'd1,
        RD_FLUSH = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic under_rd;
        logic over_rd;
        logic underrun;
        logic rx_done;
        logic rst_done;
    } srm_evt_t;
endpackage

// File: rtl/srm_fifo.sv
`timescale 1ns/1ps
module srm_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           push,
    input  logic [WIDTH-1:0]               wdata,
    input  logic                           pop,
    output logic [WIDTH-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           full,
    output logic                           empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_push_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/srm_ingress.sv
`timescale 1ns/1ps
module srm_ingress #(
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             s_tvalid,
    input  logic             s_tlast,
    input  logic             data_full,
    input  logic             len_full,
    output logic             s_tready,
    output logic             data_push,
    output logic             len_push,
    output logic [LEN_W-1:0] len_words
);
    logic [LEN_W-1:0] word_cnt;

    assign s_tready  = !flush && !data_full && !len_full;
    assign data_push = s_tvalid && s_tready;
    assign len_push  = data_push && s_tlast;
    assign len_words = word_cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            word_cnt <= '0;
        end else if (data_push) begin
            word_cnt <= s_tlast ? '0 : word_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/srm_rd_ctrl.sv
`timescale 1ns/1ps
module srm_rd_ctrl
    import srm_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_len,
    input  logic             rd_data,
    input  logic             rst_key,
    input  logic             len_empty,
    input  logic [LEN_W-1:0] len_head,
    input  logic             data_empty,
    output logic             len_pop,
    output logic             data_pop,
    output logic             data_ok,
    output logic             flush,
    output logic             ev_under_rd,
    output logic             ev_over_rd,
    output logic             ev_underrun,
    output logic             ev_rst_done
);
    rd_state_e        state, nxt_state;
    logic [LEN_W-1:0] budget, nxt_budget;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RD_IDLE;
            budget <= '0;
        end else begin
            state  <= nxt_state;
            budget <= nxt_budget;
        end
    end

    assign flush   = (state == RD_FLUSH);
    assign data_ok = (state == RD_DRAIN) && !data_empty;

    always_comb begin
        nxt_state   = state;
        nxt_budget  = budget;
        len_pop     = 1'b0;
        data_pop    = 1'b0;
        ev_under_rd = 1'b0;
        ev_over_rd  = 1'b0;
        ev_underrun = 1'b0;
        ev_rst_done = 1'b0;
        unique case (state)
            RD_FLUSH: begin
                nxt_state   = RD_IDLE;
                nxt_budget  = '0;
                ev_rst_done = 1'b1;
            end
            RD_IDLE, RD_DRAIN: begin
                if (rd_len) begin
                    ev_under_rd = (state == RD_DRAIN);
                    if (!len_empty) begin
                        len_pop    = 1'b1;
                        nxt_budget = len_head;
                        nxt_state  = (len_head == '0) ? RD_IDLE : RD_DRAIN;
                    end else begin
                        nxt_budget = '0;
                        nxt_state  = RD_IDLE;
                    end
                end else if (rd_data) begin
                    if (data_empty) begin
                        ev_underrun = 1'b1;
                    end else if (state == RD_IDLE) begin
                        ev_over_rd = 1'b1;
                    end else begin
                        data_pop   = 1'b1;
                        nxt_budget = budget - 1'b1;
                        if (budget == LEN_W'(1)) nxt_state = RD_IDLE;
                    end
                end
            end
            default: begin
                nxt_state  = RD_IDLE;
                nxt_budget = '0;
            end
        endcase
        if (rst_key) begin
            nxt_state  = RD_FLUSH;
            nxt_budget = '0;
            len_pop    = 1'b0;
            data_pop   = 1'b0;
        end
    end

    assert_idle_no_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_IDLE) |-> (budget == '0));
    assert_drain_has_budget_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_DRAIN) |-> (budget != '0));
    assert_flush_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_FLUSH && !rst_key) |=> (state == RD_IDLE));
    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_FLUSH) |=> (len_empty && data_empty));
endmodule

// File: rtl/srm_irq_regs.sv
`timescale 1ns/1ps
module srm_irq_regs
    import srm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  srm_evt_t    evt,
    input  logic        sts_we,
    input  logic        en_we,
    input  logic        wipe,
    input  logic [31:0] wdata,
    output logic [31:0] status,
    output logic [31:0] enable,
    output logic        irq
);
    logic [31:0] set_vec;

    always_comb begin
        set_vec = '0;
        set_vec[BIT_UNDER_RD] = evt.under_rd;
        set_vec[BIT_OVER_RD]  = evt.over_rd;
        set_vec[BIT_UNDERRUN] = evt.underrun;
        set_vec[BIT_RX_DONE]  = evt.rx_done;
        set_vec[BIT_RST_DONE] = evt.rst_done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~(sts_we ? wdata : 32'd0)) | set_vec;
            if (en_we) enable <= wdata & IRQ_MASK;
        end
    end

    assign irq = |(status & enable);

    assert_rx_done_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[BIT_RX_DONE]) |-> $past(evt.rx_done));
    assert_status_in_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~IRQ_MASK) == 32'd0);
endmodule

// File: rtl/stream_rx_mailbox.sv
`timescale 1ns/1ps
module stream_rx_mailbox
    import srm_pkg::*;
#(
    parameter int DATA_DEPTH    = 16,
    parameter int LEN_DEPTH     = 4,
    parameter int MAX_PKT_WORDS = 16383
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] s_tdata,
    input  logic        s_tvalid,
    input  logic        s_tlast,
    output logic        s_tready,
    input  logic [5:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    input  logic        reg_rd,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int LEN_W = $clog2(MAX_PKT_WORDS + 1);
    localparam int DCW   = $clog2(DATA_DEPTH + 1);
    localparam int LCW   = $clog2(LEN_DEPTH + 1);

    logic             rd_len, rd_data, rx_key, strm_key, rst_key;
    logic             sts_we, en_we;
    logic             flush, data_push, len_push, len_pop, data_pop, data_ok;
    logic             data_full, data_empty, len_full, len_empty;
    logic [31:0]      data_head;
    logic [DCW-1:0]   data_count;
    logic [LCW-1:0]   len_count;
    logic [LEN_W-1:0] len_words, len_head;
    logic             ev_under_rd, ev_over_rd, ev_underrun, ev_rst_done;
    srm_evt_t         evt;
    logic [31:0]      status, enable;

    assign rd_len   = reg_rd && (reg_addr == OFS_LEN);
    assign rd_data  = reg_rd && (reg_addr == OFS_DATA);
    assign rx_key   = reg_wr && (reg_addr == OFS_RXRST)   && (reg_wdata == RESET_KEY);
    assign strm_key = reg_wr && (reg_addr == OFS_STRMRST) && (reg_wdata == RESET_KEY);
    assign rst_key  = rx_key || strm_key;
    assign sts_we   = reg_wr && (reg_addr == OFS_STATUS);
    assign en_we    = reg_wr && (reg_addr == OFS_ENABLE);

    srm_ingress #(.LEN_W(LEN_W)) ingress_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .s_tvalid(s_tvalid), .s_tlast(s_tlast),
        .data_full(data_full), .len_full(len_full),
        .s_tready(s_tready), .data_push(data_push),
        .len_push(len_push), .len_words(len_words)
    );

    srm_fifo #(.WIDTH(32), .DEPTH(DATA_DEPTH)) data_q_i (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .push(data_push), .wdata(s_tdata),
        .pop(data_pop), .rdata(data_head), .count(data_count),
        .full(data_full), .empty(data_empty)
    );

    srm_fifo #(.WIDTH(LEN_W), .DEPTH(LEN_DEPTH)) len_q_i (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .push(len_push), .wdata(len_words),
        .pop(len_pop), .rdata(len_head), .count(len_count),
        .full(len_full), .empty(len_empty)
    );

    srm_rd_ctrl #(.LEN_W(LEN_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .rd_len(rd_len), .rd_data(rd_data), .rst_key(rst_key),
        .len_empty(len_empty), .len_head(len_head), .data_empty(data_empty),
        .len_pop(len_pop), .data_pop(data_pop), .data_ok(data_ok), .flush(flush),
        .ev_under_rd(ev_under_rd), .ev_over_rd(ev_over_rd),
        .ev_underrun(ev_underrun), .ev_rst_done(ev_rst_done)
    );

    always_comb begin
        evt.under_rd = ev_under_rd;
        evt.over_rd  = ev_over_rd;
        evt.underrun = ev_underrun;
        evt.rx_done  = len_push;
        evt.rst_done = ev_rst_done;
    end

    srm_irq_regs irq_i (
        .clk(clk), .rst_n(rst_n), .evt(evt),
        .sts_we(sts_we), .en_we(en_we), .wipe(strm_key), .wdata(reg_wdata),
        .status(status), .enable(enable), .irq(irq)
    );

    always_comb begin
        case (reg_addr)
            OFS_STATUS: reg_rdata = status;
            OFS_ENABLE: reg_rdata = enable;
            OFS_OCC:    reg_rdata = 32'(data_count);
            OFS_LEN:    reg_rdata = len_empty ? 32'd0 : 32'({len_head, 2'b00});
            OFS_DATA:   reg_rdata = data_ok ? data_head : 32'd0;
            default:    reg_rdata = 32'd0;
        endcase
    end

    assert_key_stalls_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rst_key |=> !s_tready);
    assert_len_full_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (len_count == LCW'(LEN_DEPTH)) |-> !s_tready);
endmodule

// File: tb/stream_rx_mailbox_tb_top.sv
`timescale 1ns/1ps
module stream_rx_mailbox_tb_top;
    localparam int DD = 16;
    localparam int LD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tlast = 1'b0;
    logic        s_tready;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [5:0] A_STS = 6'h00, A_EN = 6'h04, A_OCC = 6'h08, A_LEN = 6'h0C,
                           A_DAT = 6'h10, A_RXR = 6'h14, A_SRR = 6'h18;

    always #2.5 clk = ~clk;

    stream_rx_mailbox #(.DATA_DEPTH(DD), .LEN_DEPTH(LD)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic send_pkt(input int n, input logic [31:0] base, input bit with_last);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s_tdata  = base + 32'(i);
            s_tlast  = with_last && (i == n - 1);
            s_tvalid = 1'b1;
            while (!s_tready) @(negedge clk);
        end
        @(negedge clk);
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic clear_sts();
        wr(A_STS, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_STS, d); chk("R1 status", d, 32'h0);
        rd(A_EN, d);  chk("R1 enable", d, 32'h0);
        rd(A_OCC, d); chk("R1 occupancy", d, 32'h0);
        chk("R1 tready", 32'(s_tready), 32'h1);
        chk("R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        send_pkt(3, 32'hA000_0000, 1'b1);
        rd(A_OCC, d); chk("R3 occupancy 3", d, 32'd3);
        rd(A_STS, d); chk("R6 rx done bit 26", d, 32'h0400_0000);
        rd(A_LEN, d); chk("R4 length bytes", d, 32'd12);
        for (int i = 0; i < 3; i++) begin
            rd(A_DAT, d); chk("R5 data order", d, 32'hA000_0000 + 32'(i));
        end
        rd(A_OCC, d); chk("R3 occupancy drained", d, 32'd0);
        rd(A_STS, d); chk("R5 no error bits after exact drain", d, 32'h0400_0000);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, d); chk("R12 enable mask", d, 32'hE480_0000);
        #1 chk("R12 irq asserted", 32'(irq), 32'h1);
        wr(A_STS, 32'h0400_0000);
        rd(A_STS, d); chk("R12 w1c clears", d, 32'h0);
        #1 chk("R12 irq dropped", 32'(irq), 32'h0);
        wr(A_EN, 32'h0);
    endtask

    task automatic t_over_read();
        logic [31:0] d;
        clear_sts();
        send_pkt(2, 32'h1000, 1'b1);
        send_pkt(1, 32'h2000, 1'b1);
        rd(A_LEN, d); chk("R4 first length", d, 32'd8);
        rd(A_DAT, d); chk("R5 word0", d, 32'h1000);
        rd(A_DAT, d); chk("R5 word1", d, 32'h1001);
        rd(A_DAT, d); chk("R7 over-read returns 0", d, 32'h0);
        rd(A_STS, d); chk("R7 over-read bit 30", d, 32'h4400_0000);
        rd(A_OCC, d); chk("R7 no pop on over-read", d, 32'd1);
        rd(A_LEN, d); chk("R4 second length", d, 32'd4);
        rd(A_DAT, d); chk("R7 next packet intact", d, 32'h2000);
    endtask

    task automatic t_under_read();
        logic [31:0] d;
        clear_sts();
        send_pkt(3, 32'h3000, 1'b1);
        send_pkt(1, 32'h4000, 1'b1);
        rd(A_LEN, d); chk("R8 length A", d, 32'd12);
        rd(A_DAT, d); chk("R8 word A0", d, 32'h3000);
        rd(A_LEN, d); chk("R8 length B after early reread", d, 32'd4);
        rd(A_STS, d); chk("R8 under-read bit 31", d, 32'h8400_0000);
    endtask

    task automatic t_flush_underrun();
        logic [31:0] d;
        wr(A_RXR, 32'h0000_00A5);
        #1 chk("R13 tready low in flush cycle", 32'(s_tready), 32'h0);
        rd(A_OCC, d); chk("R10 flush empties fifo", d, 32'd0);
        rd(A_STS, d); chk("R10 reset done bit 23", d & 32'h0080_0000, 32'h0080_0000);
        clear_sts();
        rd(A_LEN, d); chk("R4 empty length 0", d, 32'd0);
        rd(A_DAT, d); chk("R9 underrun returns 0", d, 32'h0);
        rd(A_STS, d); chk("R9 underrun bit 29 only", d, 32'h2000_0000);
    endtask

    task automatic t_partial_flush();
        logic [31:0] d;
        clear_sts();
        send_pkt(2, 32'h5000, 1'b0);
        rd(A_OCC, d); chk("R3 partial occupancy", d, 32'd2);
        rd(A_LEN, d); chk("R4 no complete packet", d, 32'd0);
        wr(A_RXR, 32'h0000_005A);
        rd(A_OCC, d); chk("R10 wrong key ignored", d, 32'd2);
        rd(A_STS, d); chk("R10 wrong key no status", d, 32'h0);
        wr(A_RXR, 32'h0000_00A5);
        rd(A_OCC, d); chk("R10 key flushes partial", d, 32'd0);
        send_pkt(1, 32'h6000, 1'b1);
        rd(A_LEN, d); chk("R10 counter cleared by flush", d, 32'd4);
        rd(A_DAT, d); chk("R5 post-flush word", d, 32'h6000);
    endtask

    task automatic t_backpressure();
        logic [31:0] d;
        clear_sts();
        for (int p = 0; p < LD; p++) send_pkt(1, 32'h7000 + 32'(p), 1'b1);
        #1 chk("R2 tready low, length queue full", 32'(s_tready), 32'h0);
        rd(A_OCC, d); chk("R3 occupancy 4", d, 32'd4);
        rd(A_LEN, d); chk("R2 length while full", d, 32'd4);
        #1 chk("R2 tready back after length pop", 32'(s_tready), 32'h1);
        rd(A_DAT, d); chk("R5 word p0", d, 32'h7000);
        for (int p = 1; p < LD; p++) begin
            rd(A_LEN, d);
            rd(A_DAT, d); chk("R5 word pN", d, 32'h7000 + 32'(p));
        end
        send_pkt(DD, 32'h8000, 1'b1);
        #1 chk("R2 tready low, data fifo full", 32'(s_tready), 32'h0);
        rd(A_OCC, d); chk("R3 occupancy full", d, 32'(DD));
        rd(A_LEN, d); chk("R4 long length", d, 32'(4 * DD));
        for (int i = 0; i < DD; i++) begin
            rd(A_DAT, d); chk("R5 long data", d, 32'h8000 + 32'(i));
        end
        rd(A_STS, d); chk("R6 status clean after drain", d, 32'h0400_0000);
    endtask

    task automatic t_stream_reset();
        logic [31:0] d;
        wr(A_EN, 32'h0400_0000);
        send_pkt(2, 32'h9000, 1'b1);
        #1 chk("R12 irq on rx done", 32'(irq), 32'h1);
        wr(A_SRR, 32'h0000_00A5);
        rd(A_EN, d);  chk("R11 enable cleared", d, 32'h0);
        rd(A_STS, d); chk("R11 status only bit 23", d, 32'h0080_0000);
        rd(A_OCC, d); chk("R11 fifo emptied", d, 32'h0);
        chk("R11 irq low", 32'(irq), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_irq();
        t_over_read();
        t_under_read();
        t_flush_underrun();
        t_partial_flush();
        t_backpressure();
        t_stream_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule